// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Sequencer

This block is the bus interface unit of a small 8-bit processor whose low address byte and data byte share one set of pins. The core hands it a request made of a cycle kind, a 16-bit address, a write byte and a flag that selects the long form of fetch-like cycles. The request is accepted with a valid/ready pair. The sequencer then walks through its T states and drives these outputs:

- the high address byte;
- the shared low address/data byte, with an output enable;
- the address latch strobe;
- the read, write and interrupt-acknowledge strobes, all active low;
- the memory/IO select and the two status bits.

For a read, the byte on the shared pins is returned to the core. A one-cycle completion pulse marks the end of every cycle. A low READY stretches the transfer with wait states. A high HOLD hands the bus to another master once the current cycle has finished.

The state set is named `TS_RESET`, `TS_HALT`, `TS_T1`, `TS_T2`, `TS_WAIT`, `TS_T3`, `TS_T4`, `TS_T5`, `TS_T6` and `TS_HOLD`. `TS_HALT` is the idle state, with the bus floating. The transitions are:

- `TS_RESET` → `TS_HALT` on the first clock after reset.
- `TS_HALT`/`TS_HOLD` → `TS_HOLD` while HOLD is high. Otherwise they go to `TS_T1` on an accepted request, and to `TS_HALT` when there is none.
- `TS_T1` → `TS_T2`.
- `TS_T2`/`TS_WAIT` → `TS_WAIT` while READY is low, else `TS_T3`.
- `TS_T3` → `TS_T4` for fetch and interrupt acknowledge. Otherwise the cycle ends.
- `TS_T4` → `TS_T5` for the long form. Otherwise the cycle ends.
- `TS_T5` → `TS_T6`.
- `TS_T6` ends the cycle.
- At the end of a cycle the state goes to `TS_HOLD` if HOLD is pending. Otherwise it goes to `TS_T1` if a new request is accepted in the same clock, else to `TS_HALT`.

Top module: `mbus_cycle_seq`

## Requirements
- R1: Memory read, memory write, I/O read, I/O write and bus idle cycles last three T states. Fetch (kind 0) and interrupt acknowledge (kind 5) last four T states, or six when `req_long` is 1. Each wait state adds one state.
- R2: `stat` is 2'b11 for fetch and interrupt acknowledge, 2'b10 for memory read, I/O read and bus idle, and 2'b01 for writes. `io_m` is 1 for I/O read (kind 3), I/O write (kind 4) and interrupt acknowledge, and 0 otherwise. Both are valid from T1 to the last state of the cycle.
- R3: `ale` is high for exactly the T1 state of every cycle except bus idle (kind 6). In that state the low address is driven on `ad_out` with `ad_oe` high. Bus idle leaves `ad_oe` low in T1.
- R4: For I/O read and I/O write cycles, the port number `req_addr[7:0]` appears on `addr_hi` and on `ad_out` in T1. Memory cycles put `req_addr[15:8]` on `addr_hi`.
- R5: `rd_n` is low in T2, wait states and T3 of fetch, memory read (kind 1) and I/O read. `wr_n` is low in those states for memory write (kind 2) and I/O write. `inta_n` is low in those states for interrupt acknowledge. No strobe is active in T1, T4–T6, or in any state of a bus idle cycle.
- R6: During writes, `ad_out` carries the write byte with `ad_oe` high from T2 through T3.
- R7: READY sampled low at the edge ending T2 or a wait state inserts or extends the wait state. Sampled high, it moves the cycle to T3.
- R8: `rd_data` takes the shared bus byte at the edge ending T3 of a reading cycle and keeps it through later non-reading cycles. `cyc_done` pulses for one clock after the last state of each cycle.
- R9: HOLD seen high at T2 or later lets the cycle finish, then enters the hold state. In the hold state `hlda` is 1, `addr_oe`, `ad_oe` and `ctl_oe` are 0, and `req_ready` is 0. The block leaves the hold state one clock after HOLD falls.
- R10: During reset all output enables, `ale`, `hlda` and `cyc_done` are 0 and all strobes are high. After reset the idle state keeps the bus floating and raises `req_ready`.
- R11: In T4–T6, `ale` is 0 and `ad_oe` is 0, while `addr_oe` stays 1 and `io_m` keeps its cycle value (1 for interrupt acknowledge).
- R12: `req_ready` is 1 in the last state of a cycle when no HOLD is pending, so a request held valid starts its T1 right after that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_kind | input | 3 | 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write, 5 int ack, 6 bus idle (7 treated as 6) |
| req_addr | input | 16 | Cycle address (port number in bits 7:0 for I/O) |
| req_wdata | input | 8 | Write byte |
| req_long | input | 1 | Selects the six-state form of fetch/int ack |
| req_ready | output | 1 | Request accepted on this edge when valid |
| ready | input | 1 | Slow-device ready, high to proceed |
| hold | input | 1 | Bus request from another master |
| ad_in | input | 8 | Byte read from the shared pins |
| addr_hi | output | 8 | High address byte |
| addr_oe | output | 1 | Output enable of addr_hi |
| ad_out | output | 8 | Byte driven on the shared pins |
| ad_oe | output | 1 | Output enable of the shared pins |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| io_m | output | 1 | 1 for I/O and int ack cycles |
| stat | output | 2 | Cycle status bits |
| ctl_oe | output | 1 | Output enable of rd_n, wr_n and io_m |
| hlda | output | 1 | Hold acknowledge |
| rd_data | output | 8 | Last byte read |
| cyc_done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The hardest case is a HOLD that rises in the middle of a cycle while the core already has the next request waiting. The bus must finish its transfer, refuse the queued request, and only then float. The stimulus raises HOLD in T2 of a memory read and keeps the next request pending. It then checks that the last state refuses the request and that the following clock floats every enable with `hlda` high. Back-to-back starts and wait-state stretching come from the driver re-asserting `req_valid` in the last state and from holding READY low for a chosen count of wait states.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [3:0] {
        TS_T1    = 4'd0,
        TS_T2    = 4'd1,
        TS_WAIT  = 4'd2,
        TS_T3    = 4'd3,
        TS_T4    = 4'd4,
        TS_T5    = 4'd5,
        TS_T6    = 4'd6,
        TS_RESET = 4'd7,
        TS_HALT  = 4'd8,
        TS_HOLD  = 4'd9
    } tstate_e;

    typedef enum logic [2:0] {
        CK_FETCH  = 3'd0,
        CK_MEMRD  = 3'd1,
        CK_MEMWR  = 3'd2,
        CK_IORD   = 3'd3,
        CK_IOWR   = 3'd4,
        CK_INTACK = 3'd5,
        CK_IDLE   = 3'd6,
        CK_RSVD   = 3'd7
    } ckind_e;

    // cycles that continue past T3
    function automatic logic kind_extended(ckind_e k);
        return (k == CK_FETCH) || (k == CK_INTACK);
    endfunction

    function automatic logic kind_is_io(ckind_e k);
        return (k == CK_IORD) || (k == CK_IOWR);
    endfunction

    function automatic logic kind_reads(ckind_e k);
        return (k == CK_FETCH) || (k == CK_MEMRD) || (k == CK_IORD) || (k == CK_INTACK);
    endfunction

    function automatic logic kind_writes(ckind_e k);
        return (k == CK_MEMWR) || (k == CK_IOWR);
    endfunction

    function automatic logic kind_iom(ckind_e k);
        return kind_is_io(k) || (k == CK_INTACK);
    endfunction

    function automatic logic [1:0] kind_status(ckind_e k);
        logic [1:0] s;
        case (k)
            CK_FETCH, CK_INTACK: s = 2'b11;
            CK_MEMWR, CK_IOWR:   s = 2'b01;
            default:             s = 2'b10;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mbus_tseq.sv
module mbus_tseq
    import mbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    ready,
    input  logic    hold,
    input  logic    ext,
    input  logic    six,
    output tstate_e state,
    output logic    req_ready,
    output logic    start,
    output logic    last
);

    tstate_e nxt;
    tstate_e end_next;
    logic    hold_seen;
    logic    go_hold;
    logic    in_xfer;

    assign in_xfer = (state == TS_T2) || (state == TS_WAIT) || (state == TS_T3) ||
                     (state == TS_T4) || (state == TS_T5) || (state == TS_T6);

    always_comb begin
        unique case (state)
            TS_T3:   last = !ext;
            TS_T4:   last = !six;
            TS_T6:   last = 1'b1;
            default: last = 1'b0;
        endcase
    end

    assign go_hold = hold_seen | hold;

    always_comb begin
        if ((state == TS_HALT) || (state == TS_HOLD))
            req_ready = !hold;
        else
            req_ready = last && !go_hold;
    end

    assign start = req_valid && req_ready;

    always_comb begin
        if (go_hold)        end_next = TS_HOLD;
        else if (req_valid) end_next = TS_T1;
        else                end_next = TS_HALT;
    end

    always_comb begin
        unique case (state)
            TS_RESET:         nxt = TS_HALT;
            TS_HALT, TS_HOLD: nxt = hold ? TS_HOLD : (req_valid ? TS_T1 : TS_HALT);
            TS_T1:            nxt = TS_T2;
            TS_T2, TS_WAIT:   nxt = ready ? TS_T3 : TS_WAIT;
            TS_T3:            nxt = ext ? TS_T4 : end_next;
            TS_T4:            nxt = six ? TS_T5 : end_next;
            TS_T5:            nxt = TS_T6;
            TS_T6:            nxt = end_next;
            default:          nxt = TS_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_RESET;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                hold_seen <= 1'b0;
        else if (last)             hold_seen <= 1'b0;
        else if (in_xfer && hold)  hold_seen <= 1'b1;
    end

    // R1
    t1_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_T1) |=> (state == TS_T2));

    // R7
    wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == TS_T2) && !ready) |=> (state == TS_WAIT));

    // R9
    hold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == TS_HOLD) && hold) |=> (state == TS_HOLD));

endmodule

// File: rtl/mbus_pindrv.sv
module mbus_pindrv
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  tstate_e             state,
    input  ckind_e              kind,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                addr_oe,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic                inta_n,
    output logic                io_m,
    output logic [1:0]          stat,
    output logic                ctl_oe,
    output logic                hlda
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0] hi_val;
    logic            strobe_rd;
    logic            strobe_wr;
    logic            strobe_ia;

    assign hi_val    = kind_is_io(kind) ? HI_W'(addr[DATA_W-1:0]) : addr[ADDR_W-1:DATA_W];
    assign strobe_rd = kind_reads(kind) && (kind != CK_INTACK);
    assign strobe_wr = kind_writes(kind);
    assign strobe_ia = (kind == CK_INTACK);

    always_comb begin
        addr_hi = '0;
        addr_oe = 1'b0;
        ad_out  = '0;
        ad_oe   = 1'b0;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        inta_n  = 1'b1;
        io_m    = 1'b0;
        stat    = 2'b00;
        ctl_oe  = 1'b0;
        hlda    = 1'b0;
        unique case (state)
            TS_T1: begin
                addr_hi = hi_val;
                addr_oe = 1'b1;
                ctl_oe  = 1'b1;
                io_m    = kind_iom(kind);
                stat    = kind_status(kind);
                ale     = (kind != CK_IDLE);
                ad_oe   = (kind != CK_IDLE);
                ad_out  = addr[DATA_W-1:0];
            end
            TS_T2, TS_WAIT, TS_T3: begin
                addr_hi = hi_val;
                addr_oe = 1'b1;
                ctl_oe  = 1'b1;
                io_m    = kind_iom(kind);
                stat    = kind_status(kind);
                rd_n    = !strobe_rd;
                wr_n    = !strobe_wr;
                inta_n  = !strobe_ia;
                if (strobe_wr) begin
                    ad_oe  = 1'b1;
                    ad_out = wdata;
                end
            end
            TS_T4, TS_T5, TS_T6: begin
                addr_hi = hi_val;
                addr_oe = 1'b1;
                ctl_oe  = 1'b1;
                io_m    = kind_iom(kind);
                stat    = kind_status(kind);
            end
            TS_HOLD: begin
                hlda = 1'b1;
            end
            default: begin
                hlda = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mbus_rxcap.sv
module mbus_rxcap
    import mbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tstate_e           state,
    input  logic              reads,
    input  logic              last,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              cyc_done
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            cyc_done <= 1'b0;
        end else begin
            cyc_done <= last;
            if ((state == TS_T3) && reads)
                rd_data <= ad_in;
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_long,
    output logic                     req_ready,
    input  logic                     ready,
    input  logic                     hold,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     addr_oe,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     inta_n,
    output logic                     io_m,
    output logic [1:0]               stat,
    output logic                     ctl_oe,
    output logic                     hlda,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     cyc_done
);

    tstate_e           state;
    ckind_e            cur_kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_long;
    logic              start;
    logic              last;
    ckind_e            in_kind;

    assign in_kind = (ckind_e'(req_kind) == CK_RSVD) ? CK_IDLE : ckind_e'(req_kind);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind  <= CK_IDLE;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_long  <= 1'b0;
        end else if (start) begin
            cur_kind  <= in_kind;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            cur_long  <= req_long;
        end
    end

    mbus_tseq u_tseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .hold      (hold),
        .ext       (kind_extended(cur_kind)),
        .six       (cur_long),
        .state     (state),
        .req_ready (req_ready),
        .start     (start),
        .last      (last)
    );

    mbus_pindrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .state   (state),
        .kind    (cur_kind),
        .addr    (cur_addr),
        .wdata   (cur_wdata),
        .addr_hi (addr_hi),
        .addr_oe (addr_oe),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .inta_n  (inta_n),
        .io_m    (io_m),
        .stat    (stat),
        .ctl_oe  (ctl_oe),
        .hlda    (hlda)
    );

    mbus_rxcap #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .reads    (kind_reads(cur_kind)),
        .last     (last),
        .ad_in    (ad_in),
        .rd_data  (rd_data),
        .cyc_done (cyc_done)
    );

    // R3
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);

    // R9
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_HOLD) |-> (!addr_oe && !ad_oe && !ctl_oe && hlda));

endmodule

// File: tb/tb_mbus_cycle_seq.sv
module tb_mbus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_long = 1'b0;
    logic        req_ready;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  addr_hi;
    logic        addr_oe;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic        ale, rd_n, wr_n, inta_n, io_m, ctl_oe, hlda, cyc_done;
    logic [1:0]  stat;
    logic [7:0]  rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int tick    = 0;
    bit done_rep = 0;

    typedef struct {
        logic [7:0] d;
        int         len;
        int         t0;
        bit         rd;
    } exp_t;
    exp_t sb[$];
    logic [7:0] last_rd = 8'h00;

    always #5 clk = ~clk;

    mbus_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_long(req_long),
        .req_ready(req_ready), .ready(ready), .hold(hold), .ad_in(ad_in),
        .addr_hi(addr_hi), .addr_oe(addr_oe), .ad_out(ad_out), .ad_oe(ad_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .io_m(io_m),
        .stat(stat), .ctl_oe(ctl_oe), .hlda(hlda), .rd_data(rd_data),
        .cyc_done(cyc_done)
    );

    always @(posedge clk) tick <= tick + 1;

    task automatic check(bit ok, string rq, string what, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic report();
        if (!done_rep) begin
            done_rep = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    // peripheral model: latch address at ALE, return a function of it
    always @(negedge clk) begin
        if (ale) ad_in <= ad_out ^ addr_hi ^ 8'h5A;
    end

    // monitor: pop expected items at each completion pulse
    always @(negedge clk) begin
        if (rst_n && cyc_done) begin
            if (sb.size() == 0) begin
                check(0, "R8", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check((tick - e.t0) == e.len, "R1", "cycle length", tick - e.t0, e.len);
                check(rd_data == e.d, "R8", "rd_data", int'(rd_data), int'(e.d));
            end
        end
    end

    function automatic logic [1:0] exp_stat(int k);
        if (k == 0 || k == 5) return 2'b11;
        if (k == 2 || k == 4) return 2'b01;
        return 2'b10;
    endfunction

    task automatic strobes(int k, bit active, string rq);
        bit er, ew, ei;
        er = active && (k == 0 || k == 1 || k == 3);
        ew = active && (k == 2 || k == 4);
        ei = active && (k == 5);
        check(rd_n == !er, rq, "rd_n", int'(rd_n), int'(!er));
        check(wr_n == !ew, rq, "wr_n", int'(wr_n), int'(!ew));
        check(inta_n == !ei, rq, "inta_n", int'(inta_n), int'(!ei));
    endtask

    task automatic run_cyc(int k, logic [15:0] a, logic [7:0] wd, bit lng, int nw, bit hold_mid);
        bit ext, io, iom, rdk, wrk;
        logic [7:0] ehi, elo;
        exp_t e;
        ext = (k == 0 || k == 5);
        io  = (k == 3 || k == 4);
        iom = io || (k == 5);
        rdk = (k == 0 || k == 1 || k == 3 || k == 5);
        wrk = (k == 2 || k == 4);
        ehi = io ? a[7:0] : a[15:8];
        elo = a[7:0];
        req_kind = 3'(k); req_addr = a; req_wdata = wd; req_long = lng;
        req_valid = 1'b1;
        ready = (nw == 0);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        // T1
        e.t0 = tick;
        e.len = (ext ? (lng ? 6 : 4) : 3) + nw;
        e.rd = rdk;
        if (rdk) last_rd = elo ^ ehi ^ 8'h5A;
        e.d = last_rd;
        sb.push_back(e);
        check(ale == (k != 6), "R3", "ale in T1", int'(ale), int'(k != 6));
        check(ad_oe == (k != 6), "R3", "ad_oe in T1", int'(ad_oe), int'(k != 6));
        if (k != 6) check(ad_out == elo, "R4", "low address", int'(ad_out), int'(elo));
        check(addr_hi == ehi && addr_oe, "R4", "high address", int'(addr_hi), int'(ehi));
        check(stat == exp_stat(k), "R2", "status", int'(stat), int'(exp_stat(k)));
        check(io_m == iom, "R2", "io_m", int'(io_m), int'(iom));
        strobes(k, 0, "R5");
        // T2
        @(negedge clk);
        if (hold_mid) hold = 1'b1;
        check(ale == 0, "R3", "ale after T1", int'(ale), 0);
        strobes(k, k != 6, "R5");
        if (wrk) check(ad_oe && ad_out == wd, "R6", "write data T2", int'(ad_out), int'(wd));
        for (int w = 1; w <= nw; w++) begin
            @(negedge clk);
            ready = (w == nw);
            strobes(k, k != 6, "R7");
            check(stat == exp_stat(k), "R7", "status in wait", int'(stat), int'(exp_stat(k)));
        end
        // T3
        @(negedge clk);
        ready = 1'b1;
        strobes(k, k != 6, "R5");
        if (wrk) check(ad_oe && ad_out == wd, "R6", "write data T3", int'(ad_out), int'(wd));
        if (!ext) check(req_ready == !hold_mid, "R12", "ready in last", int'(req_ready), int'(!hold_mid));
        if (ext) begin
            for (int s = 4; s <= (lng ? 6 : 4); s++) begin
                @(negedge clk);
                check(!ale && !ad_oe && addr_oe, "R11", "bus in T4-T6", int'({ale, ad_oe, addr_oe}), 1);
                check(io_m == iom, "R11", "io_m in T4-T6", int'(io_m), int'(iom));
                strobes(k, 0, "R11");
            end
            check(req_ready == !hold_mid, "R12", "ready in last", int'(req_ready), int'(!hold_mid));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(0, "WD", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        check(!addr_oe && !ad_oe && !ctl_oe, "R10", "enables in reset", int'({addr_oe, ad_oe, ctl_oe}), 0);
        check(!ale && !hlda && !cyc_done, "R10", "ale/hlda/done in reset", int'({ale, hlda, cyc_done}), 0);
        check(rd_n && wr_n && inta_n, "R10", "strobes in reset", int'({rd_n, wr_n, inta_n}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !addr_oe && !ad_oe, "R10", "idle after reset", int'({req_ready, addr_oe, ad_oe}), 4);

        run_cyc(0, 16'h1234, 8'h00, 0, 0, 0);   // fetch, 4 states
        run_cyc(0, 16'hABCD, 8'h00, 1, 0, 0);   // fetch, 6 states, back to back
        run_cyc(1, 16'h2040, 8'h00, 0, 0, 0);   // memory read
        run_cyc(2, 16'h3001, 8'h9C, 0, 0, 0);   // memory write, rd_data held
        run_cyc(3, 16'h773C, 8'h00, 0, 0, 0);   // I/O read
        run_cyc(4, 16'h11A5, 8'h6E, 0, 2, 0);   // I/O write with 2 waits
        run_cyc(5, 16'h0038, 8'h00, 0, 0, 0);   // int ack 4
        run_cyc(5, 16'h0066, 8'h00, 1, 1, 0);   // int ack 6, 1 wait
        run_cyc(6, 16'h5555, 8'h00, 0, 0, 0);   // bus idle
        run_cyc(1, 16'hBEEF, 8'h00, 0, 3, 0);   // memory read, 3 waits

        // R9 hold raised mid cycle
        run_cyc(1, 16'h4321, 8'h00, 0, 0, 1);
        @(negedge clk);
        check(hlda == 1, "R9", "hlda after cycle", int'(hlda), 1);
        check(!addr_oe && !ad_oe && !ctl_oe, "R9", "float in hold", int'({addr_oe, ad_oe, ctl_oe}), 0);
        check(req_ready == 0, "R9", "no accept in hold", int'(req_ready), 0);
        repeat (3) @(negedge clk);
        check(hlda == 1, "R9", "hold persists", int'(hlda), 1);
        hold = 1'b0;
        @(negedge clk);
        check(hlda == 0 && req_ready, "R9", "hold released", int'({hlda, req_ready}), 1);

        // R9 hold from idle
        hold = 1'b1;
        @(negedge clk);
        check(hlda == 1 && !addr_oe, "R9", "hold from idle", int'({hlda, addr_oe}), 2);
        hold = 1'b0;
        @(negedge clk);
        check(hlda == 0, "R9", "idle hold released", int'(hlda), 0);

        run_cyc(0, 16'h0F0F, 8'h00, 0, 0, 0);
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R8", "all cycles completed", sb.size(), 0);
        report();
        $finish;
    end

endmodule